// File: doc/BRIEF.md
# Power Stage Fault Supervisor

This block sits between the digitized comparator flags of a half-bridge resonant controller and its gate driver. It receives one synchronous flag per threshold crossing. These flags cover the low-side supply (start, stop, deep-discharge and over-voltage), the high-side supply (start and stop), two current-sense levels, the control-pin overload level and the temperature limit. From these it produces one run/stop output for the gate driver and a set of status flags.

Switching is held off until both supplies have satisfied their lockout hysteresis. The moderate current fault is acted on only after the sense flag has stayed asserted for a long qualification window. The severe current fault needs only a short blanking window. Each fault goes to one of two classes:

- An auto-restart fault stops switching until the low-side supply drops through its stop threshold. The supply must then climb back to start before switching resumes.
- A latch fault stops switching and ignores all lockout cycling. It clears only when the low-side supply reports a deep discharge.

Cause vectors show which conditions put the block into its current fault class.

Top module: `fsup_top`

## Requirements
- R1: While rst_ni is low and after its release, run_o, auto_fault_o and latch_fault_o are 0, hold_o is 1, and both cause vectors are 0.
- R2: Each rail keeps an "ok" bit that a start flag sets and a stop flag clears (stop wins), holding between them. run_o rises one cycle after both rail ok bits are set. It stays high when the start flags drop again.
- R3: A stop flag on either rail while running drops run_o two clock edges after the sampled flag and returns the block to hold_o.
- R4: ocp_i sampled high for OCP_QUAL_CYC consecutive cycles enters the auto-restart class at that edge. A shorter run resets the count to zero and records nothing.
- R5: aocp_i sampled high for AOCP_BLANK_CYC consecutive cycles enters the latch class at that edge. A shorter run resets the count and records nothing.
- R6: A single sampled olp_i or lv_ovp_i while holding or running enters the auto-restart class at the next edge.
- R7: A sampled tsd_i enters the latch class at the next edge from any state.
- R8: In the auto-restart class, start flags have no effect and run_o stays 0. A sampled lv_stop_i moves the block to hold, from which both rails must reach start again.
- R9: In the latch class, start and stop flags on both rails have no effect. Only a sampled lv_reset_i with no simultaneous latch condition moves it to hold.
- R10: A latch condition takes priority over any auto-restart condition in the same cycle, and over a pending auto-restart state.
- R11: auto_cause_o (bit 0 over-current, bit 1 overload, bit 2 over-voltage) and latch_cause_o (bit 0 severe current, bit 1 thermal) capture the conditions present on entry to the class. Each is zero whenever its class is not active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lv_start_i | input | 1 | Low-side supply above start threshold |
| lv_stop_i | input | 1 | Low-side supply below stop threshold |
| lv_reset_i | input | 1 | Low-side supply below deep-discharge level |
| lv_ovp_i | input | 1 | Low-side supply over-voltage |
| hv_start_i | input | 1 | High-side supply above start threshold |
| hv_stop_i | input | 1 | High-side supply below stop threshold |
| ocp_i | input | 1 | Current sense beyond over-current level |
| aocp_i | input | 1 | Current sense beyond severe over-current level |
| olp_i | input | 1 | Control pin above overload level |
| tsd_i | input | 1 | Junction temperature limit exceeded |
| run_o | output | 1 | Gate driver may switch |
| hold_o | output | 1 | Waiting for supply lockout release |
| auto_fault_o | output | 1 | Auto-restart fault class active |
| latch_fault_o | output | 1 | Latch fault class active |
| auto_cause_o | output | 3 | Auto-restart causes captured on entry |
| latch_cause_o | output | 2 | Latch causes captured on entry |

## Verification
A wrong lockout bit or state shows at the ports within two edges. run_o then rises too early, stays high through a stop flag, or returns from a fault without the supply cycling. A qualification counter that is off by one, or that fails to clear on a short pulse, moves the fault entry by exactly one cycle or fires on a pulse one cycle short of the window. The bench therefore drives runs of exactly window-1 and window length. A cause register that is not cleared shows as a nonzero vector in the first cycle after the class exits.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_RUN   = 2'd1,
    ST_AUTO  = 2'd2,
    ST_LATCH = 2'd3
  } fsup_state_e;

  localparam int NUM_RAILS = 2;
  localparam int RAIL_LV   = 0;
  localparam int RAIL_HV   = 1;

  localparam int AUTO_W    = 3;
  localparam int AUTO_OCP  = 0;
  localparam int AUTO_OLP  = 1;
  localparam int AUTO_OVP  = 2;

  localparam int LATCH_W    = 2;
  localparam int LATCH_AOCP = 0;
  localparam int LATCH_TSD  = 1;
endpackage

// File: rtl/fsup_hyst.sv
module fsup_hyst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  output logic ok_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ok_o <= 1'b0;
    else if (stop_i)  ok_o <= 1'b0;
    else if (start_i) ok_o <= 1'b1;
  end
endmodule

// File: rtl/fsup_qual.sv
module fsup_qual #(
  parameter int N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  output logic qual_o
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(N - 1);

  logic [CW-1:0] cnt_q;

  // qual_o fires on the N-th consecutive sample
  assign qual_o = flag_i && (cnt_q == CNT_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!flag_i)                   cnt_q <= '0;
    else if (cnt_q != CNT_TOP)          cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/fsup_ctrl.sv
module fsup_ctrl
  import fsup_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rails_ok_i,
  input  logic               lv_stop_i,
  input  logic               lv_reset_i,
  input  logic [AUTO_W-1:0]  auto_ev_i,
  input  logic [LATCH_W-1:0] latch_ev_i,
  output fsup_state_e        state_o,
  output logic [AUTO_W-1:0]  auto_cause_o,
  output logic [LATCH_W-1:0] latch_cause_o
);
  fsup_state_e st_q, st_d;
  logic any_auto, any_latch;

  assign any_auto  = |auto_ev_i;
  assign any_latch = |latch_ev_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_HOLD: begin
        if (any_latch)       st_d = ST_LATCH;
        else if (any_auto)   st_d = ST_AUTO;
        else if (rails_ok_i) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (any_latch)        st_d = ST_LATCH;
        else if (any_auto)    st_d = ST_AUTO;
        else if (!rails_ok_i) st_d = ST_HOLD;
      end
      ST_AUTO: begin
        if (any_latch)      st_d = ST_LATCH;
        else if (lv_stop_i) st_d = ST_HOLD;
      end
      ST_LATCH: begin
        if (lv_reset_i && !any_latch) st_d = ST_HOLD;
      end
      default: st_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_HOLD;
    else         st_q <= st_d;
  end

  // causes snapshot on class entry, cleared on class exit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_cause_o  <= '0;
      latch_cause_o <= '0;
    end else begin
      if (st_d != ST_AUTO)      auto_cause_o <= '0;
      else if (st_q != ST_AUTO) auto_cause_o <= auto_ev_i;

      if (st_d != ST_LATCH)      latch_cause_o <= '0;
      else if (st_q != ST_LATCH) latch_cause_o <= latch_ev_i;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/fsup_top.sv
module fsup_top
  import fsup_pkg::*;
#(
  parameter int OCP_QUAL_CYC   = 188,
  parameter int AOCP_BLANK_CYC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lv_start_i,
  input  logic               lv_stop_i,
  input  logic               lv_reset_i,
  input  logic               lv_ovp_i,
  input  logic               hv_start_i,
  input  logic               hv_stop_i,
  input  logic               ocp_i,
  input  logic               aocp_i,
  input  logic               olp_i,
  input  logic               tsd_i,
  output logic               run_o,
  output logic               hold_o,
  output logic               auto_fault_o,
  output logic               latch_fault_o,
  output logic [AUTO_W-1:0]  auto_cause_o,
  output logic [LATCH_W-1:0] latch_cause_o
);
  logic [NUM_RAILS-1:0] start_v, stop_v, ok_v;
  logic ocp_q, aocp_q;
  logic [AUTO_W-1:0]  auto_ev;
  logic [LATCH_W-1:0] latch_ev;
  fsup_state_e state;

  assign start_v[RAIL_LV] = lv_start_i;
  assign start_v[RAIL_HV] = hv_start_i;
  assign stop_v[RAIL_LV]  = lv_stop_i;
  assign stop_v[RAIL_HV]  = hv_stop_i;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    fsup_hyst u_hyst (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start_v[g]),
      .stop_i (stop_v[g]),
      .ok_o   (ok_v[g])
    );
  end

  fsup_qual #(.N(OCP_QUAL_CYC)) u_ocp_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .flag_i(ocp_i),
    .qual_o(ocp_q)
  );

  fsup_qual #(.N(AOCP_BLANK_CYC)) u_aocp_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .flag_i(aocp_i),
    .qual_o(aocp_q)
  );

  always_comb begin
    auto_ev             = '0;
    auto_ev[AUTO_OCP]   = ocp_q;
    auto_ev[AUTO_OLP]   = olp_i;
    auto_ev[AUTO_OVP]   = lv_ovp_i;
    latch_ev            = '0;
    latch_ev[LATCH_AOCP] = aocp_q;
    latch_ev[LATCH_TSD]  = tsd_i;
  end

  fsup_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rails_ok_i   (&ok_v),
    .lv_stop_i    (lv_stop_i),
    .lv_reset_i   (lv_reset_i),
    .auto_ev_i    (auto_ev),
    .latch_ev_i   (latch_ev),
    .state_o      (state),
    .auto_cause_o (auto_cause_o),
    .latch_cause_o(latch_cause_o)
  );

  assign run_o         = (state == ST_RUN);
  assign hold_o        = (state == ST_HOLD);
  assign auto_fault_o  = (state == ST_AUTO);
  assign latch_fault_o = (state == ST_LATCH);
endmodule

// File: rtl/fsup_chk.sv
module fsup_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lv_stop_i,
  input logic       lv_reset_i,
  input logic       lv_ovp_i,
  input logic       ocp_i,
  input logic       olp_i,
  input logic       tsd_i,
  input logic       run_o,
  input logic       auto_fault_o,
  input logic       latch_fault_o,
  input logic [2:0] auto_cause_o,
  input logic [1:0] latch_cause_o
);
  p_stop_drops_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lv_stop_i |=> ##1 !run_o);

  p_auto_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(auto_fault_o) |-> $past(ocp_i || olp_i || lv_ovp_i));

  p_thermal_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsd_i |=> latch_fault_o);

  p_auto_no_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_fault_o |=> !run_o);

  p_latch_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_fault_o && !lv_reset_i |=> latch_fault_o);

  p_latch_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(latch_fault_o) |-> $past(lv_reset_i));

  p_latch_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_fault_o |-> latch_cause_o != 2'b00);

  p_auto_cause_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_fault_o |-> auto_cause_o == 3'b000);
endmodule

bind fsup_top fsup_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lv_stop_i    (lv_stop_i),
  .lv_reset_i   (lv_reset_i),
  .lv_ovp_i     (lv_ovp_i),
  .ocp_i        (ocp_i),
  .olp_i        (olp_i),
  .tsd_i        (tsd_i),
  .run_o        (run_o),
  .auto_fault_o (auto_fault_o),
  .latch_fault_o(latch_fault_o),
  .auto_cause_o (auto_cause_o),
  .latch_cause_o(latch_cause_o)
);

// File: tb/tb_fsup_top.sv
module tb_fsup_top;
  localparam int OCPN  = 188;
  localparam int AOCPN = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic lv_start = 0, lv_stop = 0, lv_reset = 0, lv_ovp = 0;
  logic hv_start = 0, hv_stop = 0, ocp = 0, aocp = 0, olp = 0, tsd = 0;
  logic run, hold, autof, latchf;
  logic [2:0] acause;
  logic [1:0] lcause;

  fsup_top #(.OCP_QUAL_CYC(OCPN), .AOCP_BLANK_CYC(AOCPN)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lv_start_i(lv_start), .lv_stop_i(lv_stop), .lv_reset_i(lv_reset), .lv_ovp_i(lv_ovp),
    .hv_start_i(hv_start), .hv_stop_i(hv_stop),
    .ocp_i(ocp), .aocp_i(aocp), .olp_i(olp), .tsd_i(tsd),
    .run_o(run), .hold_o(hold), .auto_fault_o(autof), .latch_fault_o(latchf),
    .auto_cause_o(acause), .latch_cause_o(lcause)
  );

  int n_cmp = 0, n_bad = 0;
  string req = "R1";
  bit finished = 0;

  // reference model: 0 hold, 1 run, 2 auto, 3 latch
  int m_st = 0, m_ocp_run = 0, m_aocp_run = 0;
  bit m_lv_ok = 0, m_hv_ok = 0;
  logic [2:0] m_acause = 0;
  logic [1:0] m_lcause = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ocp_run = 0; m_aocp_run = 0;
      m_lv_ok = 0; m_hv_ok = 0; m_acause = 0; m_lcause = 0;
    end else begin
      logic [2:0] a_ev;
      logic [1:0] l_ev;
      int nxt;
      m_ocp_run  = ocp  ? m_ocp_run + 1  : 0;
      m_aocp_run = aocp ? m_aocp_run + 1 : 0;
      a_ev = {lv_ovp, olp, m_ocp_run >= OCPN};
      l_ev = {tsd, m_aocp_run >= AOCPN};
      nxt = m_st;
      if (m_st == 3) begin
        if (lv_reset && l_ev == 0) nxt = 0;
      end else if (l_ev != 0) nxt = 3;
      else if (m_st == 2) begin
        if (lv_stop) nxt = 0;
      end else if (a_ev != 0) nxt = 2;
      else nxt = (m_lv_ok && m_hv_ok) ? 1 : 0;
      if (nxt != 2) m_acause = 0; else if (m_st != 2) m_acause = a_ev;
      if (nxt != 3) m_lcause = 0; else if (m_st != 3) m_lcause = l_ev;
      m_st = nxt;
      if (lv_stop) m_lv_ok = 0; else if (lv_start) m_lv_ok = 1;
      if (hv_stop) m_hv_ok = 0; else if (hv_start) m_hv_ok = 1;
    end
  end

  task automatic chk(string r, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk(req, "class", {run, hold, autof, latchf},
          {m_st == 1, m_st == 0, m_st == 2, m_st == 3});
      chk(req, "auto_cause", acause, m_acause);
      chk(req, "latch_cause", lcause, m_lcause);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // directed check of {run,hold,auto,latch}
  task automatic expect_cls(string r, logic [3:0] exp);
    chk(r, "directed class", {run, hold, autof, latchf}, exp);
  endtask

  task automatic restart();
    lv_stop = 1; step(1); lv_stop = 0;
    lv_start = 1; hv_start = 1; step(3);
    lv_start = 0; hv_start = 0; step(1);
  endtask

  task automatic deep_reset();
    lv_reset = 1; lv_stop = 1; step(1);
    lv_reset = 0; lv_stop = 0; step(2);
  endtask

  initial begin
    step(3);
    expect_cls("R1", 4'b0100);
    rst_n = 1; step(2);
    expect_cls("R1", 4'b0100);

    req = "R2";
    lv_start = 1; step(3); expect_cls("R2", 4'b0100);
    hv_start = 1; step(3); expect_cls("R2", 4'b1000);
    lv_start = 0; hv_start = 0; step(3); expect_cls("R2", 4'b1000);

    req = "R4";
    ocp = 1; step(OCPN - 1); ocp = 0; step(3); expect_cls("R4", 4'b1000);
    ocp = 1; step(OCPN); ocp = 0; step(2); expect_cls("R4", 4'b0010);
    chk("R11", "ocp cause", acause, 3'b001);

    req = "R8";
    lv_start = 1; hv_start = 1; step(4); expect_cls("R8", 4'b0010);
    lv_start = 0; hv_start = 0;
    lv_stop = 1; step(1); lv_stop = 0; step(2); expect_cls("R8", 4'b0100);
    lv_start = 1; hv_start = 1; step(3); lv_start = 0; hv_start = 0; step(1);
    expect_cls("R8", 4'b1000);

    req = "R6";
    olp = 1; step(1); olp = 0; step(2); expect_cls("R6", 4'b0010);
    chk("R11", "olp cause", acause, 3'b010);
    restart(); expect_cls("R6", 4'b1000);
    chk("R11", "cause cleared", acause, 3'b000);
    lv_ovp = 1; step(1); lv_ovp = 0; step(2); expect_cls("R6", 4'b0010);
    chk("R11", "ovp cause", acause, 3'b100);
    restart();

    req = "R3";
    hv_stop = 1; step(1); hv_stop = 0; step(2); expect_cls("R3", 4'b0100);
    hv_start = 1; step(3); hv_start = 0; step(1); expect_cls("R3", 4'b1000);

    req = "R5";
    aocp = 1; step(AOCPN - 1); aocp = 0; step(2); expect_cls("R5", 4'b1000);
    aocp = 1; step(AOCPN); aocp = 0; step(2); expect_cls("R5", 4'b0001);
    chk("R11", "aocp cause", lcause, 2'b01);

    req = "R9";
    lv_stop = 1; hv_stop = 1; step(2); lv_stop = 0; hv_stop = 0;
    lv_start = 1; hv_start = 1; step(4); lv_start = 0; hv_start = 0;
    expect_cls("R9", 4'b0001);
    deep_reset(); expect_cls("R9", 4'b0100);
    restart(); expect_cls("R9", 4'b1000);

    req = "R7";
    tsd = 1; step(1); tsd = 0; step(2); expect_cls("R7", 4'b0001);
    chk("R11", "tsd cause", lcause, 2'b10);
    deep_reset(); restart(); expect_cls("R7", 4'b1000);

    req = "R10";
    olp = 1; step(1); olp = 0; step(1); expect_cls("R10", 4'b0010);
    tsd = 1; step(1); tsd = 0; step(1); expect_cls("R10", 4'b0001);
    deep_reset(); restart();
    olp = 1; tsd = 1; step(1); olp = 0; tsd = 0; step(1); expect_cls("R10", 4'b0001);
    deep_reset(); restart();
    olp = 1; step(1); olp = 0; step(1);
    lv_stop = 1; tsd = 1; step(1); lv_stop = 0; tsd = 0; step(1);
    expect_cls("R10", 4'b0001);
    lv_reset = 1; tsd = 1; step(1); lv_reset = 0; tsd = 0; step(1);
    expect_cls("R9", 4'b0001);
    deep_reset(); restart(); expect_cls("R2", 4'b1000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule